// File: doc/BRIEF.md
# Vector compare to predicate unit

This block evaluates the condition of a vectorised conditional branch. It walks the elements of two source operands one per clock, compares each pair with a selectable function, and writes the outcomes into a destination predicate mask. Either operand may be a scalar, in which case its single value is compared against every element of the other. A source predicate decides which element positions take part. The branch-taken flag is raised only when every compare that took part succeeded.

A zeroing flag selects how the destination mask is written. With zeroing on, the mask is rewritten: a participating element stores its compare outcome, and a masked-out element stores 0. With zeroing off, the mask is only ever set: a passing compare sets its bit, and all other bits keep the value the mask had on entry. When neither operand is vectorised, the unit performs one ordinary scalar compare and leaves the mask untouched. Element data is fetched through an index output per source and a data input that returns that element in the same cycle.

Top module: `vcmp_pred_unit`

## Requirements
- R1: After reset, busy_o, done_o, pred_o and taken_o are all 0.
- R2: An operand is vectorised only when both its active and its vector flags are 1; the run is vectorised when either operand is. A start pulse is accepted when the unit is idle. For a vectorised run with N elements (N at least 1), done_o is high in the cycle after the N-th clock edge that follows the accepting edge. With N = 0, done_o is high in the cycle after the accepting edge. For a scalar run, done_o is high in the cycle after the first edge that follows the accepting edge. done_o is high for a single cycle.
- R3: func_i selects the compare: bit 3 swaps the two operands before comparing, bit 2 selects unsigned (1) or signed (0) ordering, and bits 1:0 select equal (00), not equal (01), less than (10) or greater or equal (11). With the swap bit set, less than gives greater than and greater or equal gives less or equal.
- R4: A source that is not vectorised has its index output held at 0 for the whole run. Its element 0 is compared against every element of the other source.
- R5: Element i takes part in the compare only when bit i of src_pred_i, captured at start, is 1.
- R6: With zeroing on, a participating element writes its compare outcome to destination bit i, and a masked-out element writes 0.
- R7: With zeroing off, a passing participating element sets destination bit i. A failing or masked-out element leaves bit i at its entry value from dst_pred_i.
- R8: taken_o is 1 exactly when no participating compare failed. It is therefore 1 when every element is masked out, and when N is 0.
- R9: In a scalar run, element 0 of each source is compared once, regardless of the source predicate. taken_o is that outcome, and pred_o equals dst_pred_i.
- R10: A start pulse that arrives while the unit is busy is ignored, along with every input that comes with it.
- R11: After done_o, pred_o and taken_o hold their values until the next accepted start.
- R12: A requested length above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a run (accepted when idle) |
| vl_i | input | CNT_W | Requested element count |
| func_i | input | 4 | Compare function select |
| rs1_act_i | input | 1 | First source is active |
| rs1_vec_i | input | 1 | First source is a vector |
| rs2_act_i | input | 1 | Second source is active |
| rs2_vec_i | input | 1 | Second source is a vector |
| src_pred_i | input | MAX_VL | Participation mask (first-source predicate) |
| dst_pred_i | input | MAX_VL | Destination mask value on entry |
| zero_i | input | 1 | Zeroing mode |
| rs1_idx_o | output | IDX_W | Element index fetched from the first source |
| rs1_data_i | input | DATA_W | First-source element at rs1_idx_o |
| rs2_idx_o | output | IDX_W | Element index fetched from the second source |
| rs2_data_i | input | DATA_W | Second-source element at rs2_idx_o |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pred_o | output | MAX_VL | Destination predicate mask |
| taken_o | output | 1 | Branch-taken outcome |

## Verification
The bench builds the unit with DATA_W = 8 and MAX_VL = 8, so CNT_W is 4 and lengths up to 15 can be requested. This brings the clamp above MAX_VL into reach, along with zero-length runs. With 8-bit data, the sign boundary at 0x80 and equal pairs are easy to hit. Random data is often drawn from a range of four values, so equal, not-equal and ordering outcomes all occur often inside a single mask. Each run sees all eight predicate bit positions.

// File: rtl/vcp_pkg.sv
// Package: shared types for the vector compare-to-predicate unit.
// Assumes a 4-bit function select laid out as {swap, unsigned, kind[1:0]}.
package vcp_pkg;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_NE = 2'b01,
        CMP_LT = 2'b10,
        CMP_GE = 2'b11
    } cmp_kind_e;

    typedef struct packed {
        logic      swap;
        logic      uns;
        cmp_kind_e kind;
    } cmp_func_t;

endpackage

// File: rtl/vcp_compare.sv
// Module: combinational element comparator.
// Swaps the operands when asked, then evaluates EQ/NE/LT/GE with signed
// or unsigned ordering. Assumes both operands have the same width.
module vcp_compare
    import vcp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    input  cmp_func_t         func_i,
    output logic              pass_o
);

    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic              less;

    // Operand order and ordering relation.
    always_comb begin
        opa  = func_i.swap ? rhs_i : lhs_i;
        opb  = func_i.swap ? lhs_i : rhs_i;
        less = func_i.uns ? (opa < opb) : ($signed(opa) < $signed(opb));
    end

    // Select the relation named by the function kind.
    always_comb begin
        unique case (func_i.kind)
            CMP_EQ:  pass_o = (opa == opb);
            CMP_NE:  pass_o = (opa != opb);
            CMP_LT:  pass_o = less;
            default: pass_o = !less;
        endcase
    end

endmodule

// File: rtl/vcp_sequencer.sv
// Module: run control and element counter.
// Accepts a start when idle, clamps the length to MAX_VL, steps one
// element per clock and pulses done. A scalar run is a single step.
// Assumes MAX_VL >= 2.
module vcp_sequencer #(
    parameter int MAX_VL = 8,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             vector_i,
    input  logic [CNT_W-1:0] vl_i,
    output logic             accept_o,
    output logic             step_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o
);

    logic             busy_q;
    logic             done_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic [CNT_W-1:0] vl_eff;
    logic [IDX_W-1:0] last_n;

    // Length clamp and index of the final step.
    always_comb begin
        vl_eff = (vl_i > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vl_i;
        last_n = vector_i ? IDX_W'(vl_eff - 1'b1) : '0;
    end

    assign accept_o = start_i && !busy_q;

    // Run state: idle, stepping, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                idx_q <= '0;
                if (vector_i && (vl_eff == '0)) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    last_q <= last_n;
                end
            end else if (busy_q) begin
                if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign step_o = busy_q;
    assign done_o = done_q;
    assign idx_o  = idx_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !start_i |=> !done_q); // R2
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q); // R2
    AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && start_i && (idx_q != last_q) |=> idx_q == IDX_W'($past(idx_q) + 1'b1)); // R10

endmodule

// File: rtl/vcp_mask.sv
// Module: destination predicate register and all-pass flag.
// Loads the entry mask at start, then applies one element outcome per
// step: rewrite mode when zeroing, set-only otherwise. In a scalar run
// the mask is untouched and the flag takes the single outcome.
module vcp_mask #(
    parameter int MAX_VL = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MAX_VL-1:0] init_i,
    input  logic              step_i,
    input  logic              vec_i,
    input  logic              zero_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              gate_i,
    input  logic              pass_i,
    output logic [MAX_VL-1:0] pred_o,
    output logic              allpass_o
);

    logic [MAX_VL-1:0] pred_q;
    logic              allpass_q;

    // Mask and all-pass update per element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q    <= '0;
            allpass_q <= 1'b0;
        end else if (load_i) begin
            pred_q    <= init_i;
            allpass_q <= 1'b1;
        end else if (step_i) begin
            if (!vec_i) begin
                allpass_q <= pass_i;
            end else if (gate_i) begin
                if (pass_i) begin
                    pred_q[idx_i] <= 1'b1;
                end else begin
                    allpass_q <= 1'b0;
                    if (zero_i) pred_q[idx_i] <= 1'b0;
                end
            end else if (zero_i) begin
                pred_q[idx_i] <= 1'b0;
            end
        end
    end

    assign pred_o    = pred_q;
    assign allpass_o = allpass_q;

    AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !zero_i |=> (pred_q & $past(pred_q)) == $past(pred_q)); // R7
    AST_MASKED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && vec_i && zero_i && !gate_i |=> !pred_q[$past(idx_i)]); // R6
    AST_SCALAR_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !vec_i |=> $stable(pred_q)); // R9
    AST_FAIL_DROPS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && gate_i && !pass_i |=> !allpass_q); // R8

endmodule

// File: rtl/vcmp_pred_unit.sv
// Module: vector compare to predicate unit (top).
// Captures the run configuration at start, fetches one element pair per
// clock through the index ports, compares and updates the predicate.
// Assumes element data arrives in the same cycle as its index.
module vcmp_pred_unit
    import vcp_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int MAX_VL = 8,
    localparam int CNT_W  = $clog2(MAX_VL + 1),
    localparam int IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  vl_i,
    input  logic [3:0]        func_i,
    input  logic              rs1_act_i,
    input  logic              rs1_vec_i,
    input  logic              rs2_act_i,
    input  logic              rs2_vec_i,
    input  logic [MAX_VL-1:0] src_pred_i,
    input  logic [MAX_VL-1:0] dst_pred_i,
    input  logic              zero_i,
    output logic [IDX_W-1:0]  rs1_idx_o,
    input  logic [DATA_W-1:0] rs1_data_i,
    output logic [IDX_W-1:0]  rs2_idx_o,
    input  logic [DATA_W-1:0] rs2_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [MAX_VL-1:0] pred_o,
    output logic              taken_o
);

    logic              r1v_now, r2v_now;
    logic              r1v_q, r2v_q, zero_q;
    cmp_func_t         func_q;
    logic [MAX_VL-1:0] spred_q;
    logic              accept, step, pass, gate;
    logic [IDX_W-1:0]  idx;

    assign r1v_now = rs1_act_i && rs1_vec_i;
    assign r2v_now = rs2_act_i && rs2_vec_i;

    // Capture the run configuration on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1v_q   <= 1'b0;
            r2v_q   <= 1'b0;
            zero_q  <= 1'b0;
            func_q  <= cmp_func_t'(4'b0);
            spred_q <= '0;
        end else if (accept) begin
            r1v_q   <= r1v_now;
            r2v_q   <= r2v_now;
            zero_q  <= zero_i;
            func_q  <= cmp_func_t'(func_i);
            spred_q <= src_pred_i;
        end
    end

    vcp_sequencer #(
        .MAX_VL (MAX_VL),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .vector_i (r1v_now || r2v_now),
        .vl_i     (vl_i),
        .accept_o (accept),
        .step_o   (step),
        .done_o   (done_o),
        .idx_o    (idx)
    );

    // Scalar sources stay on element 0; vector sources follow the counter.
    assign rs1_idx_o = r1v_q ? idx : '0;
    assign rs2_idx_o = r2v_q ? idx : '0;
    assign gate      = (r1v_q || r2v_q) ? spred_q[idx] : 1'b1;

    vcp_compare #(
        .DATA_W (DATA_W)
    ) i_cmp (
        .lhs_i  (rs1_data_i),
        .rhs_i  (rs2_data_i),
        .func_i (func_q),
        .pass_o (pass)
    );

    vcp_mask #(
        .MAX_VL (MAX_VL),
        .IDX_W  (IDX_W)
    ) i_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .init_i    (dst_pred_i),
        .step_i    (step),
        .vec_i     (r1v_q || r2v_q),
        .zero_i    (zero_q),
        .idx_i     (idx),
        .gate_i    (gate),
        .pass_i    (pass),
        .pred_o    (pred_o),
        .allpass_o (taken_o)
    );

    assign busy_o = step;

endmodule

// File: tb/test_vcmp_pred_unit.sv
module test_vcmp_pred_unit;

    localparam int DW    = 8;
    localparam int MVL   = 8;
    localparam int CNT_W = $clog2(MVL + 1);
    localparam int IDX_W = $clog2(MVL);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] vl_i = '0;
    logic [3:0]       func_i = '0;
    logic             rs1_act_i = 1'b0, rs1_vec_i = 1'b0;
    logic             rs2_act_i = 1'b0, rs2_vec_i = 1'b0;
    logic [MVL-1:0]   src_pred_i = '0, dst_pred_i = '0;
    logic             zero_i = 1'b0;
    logic [IDX_W-1:0] rs1_idx_o, rs2_idx_o;
    logic [DW-1:0]    rs1_data_i, rs2_data_i;
    logic             busy_o, done_o, taken_o;
    logic [MVL-1:0]   pred_o;

    logic [DW-1:0] mem1 [MVL];
    logic [DW-1:0] mem2 [MVL];

    int errors = 0;
    int checks = 0;
    logic [MVL-1:0] exp_pred;
    bit             exp_taken;
    int             exp_cyc;

    always #2 clk = ~clk;

    assign rs1_data_i = mem1[rs1_idx_o];
    assign rs2_data_i = mem2[rs2_idx_o];

    vcmp_pred_unit #(.DATA_W(DW), .MAX_VL(MVL)) i_vcmp_pred_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .func_i(func_i),
        .rs1_act_i(rs1_act_i), .rs1_vec_i(rs1_vec_i),
        .rs2_act_i(rs2_act_i), .rs2_vec_i(rs2_vec_i),
        .src_pred_i(src_pred_i), .dst_pred_i(dst_pred_i), .zero_i(zero_i),
        .rs1_idx_o(rs1_idx_o), .rs1_data_i(rs1_data_i),
        .rs2_idx_o(rs2_idx_o), .rs2_data_i(rs2_data_i),
        .busy_o(busy_o), .done_o(done_o), .pred_o(pred_o), .taken_o(taken_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference compare from the function encoding in R3.
    function automatic bit ref_cmp(input logic [3:0] f, input logic [DW-1:0] x,
                                   input logic [DW-1:0] y);
        logic [DW-1:0] a, b;
        bit lt;
        a  = f[3] ? y : x;
        b  = f[3] ? x : y;
        lt = f[2] ? (a < b) : ($signed(a) < $signed(b));
        case (f[1:0])
            2'b00:   return a == b;
            2'b01:   return a != b;
            2'b10:   return lt;
            default: return !lt;
        endcase
    endfunction

    // Expected mask, taken flag and latency (R2, R4-R9, R12).
    task automatic model(input logic [3:0] f, input bit v1, input bit v2, input int vl,
                         input logic [MVL-1:0] sp, input logic [MVL-1:0] dp, input bit z);
        int n;
        bit c;
        n = (vl > MVL) ? MVL : vl;
        if (!(v1 || v2)) begin
            exp_taken = ref_cmp(f, mem1[0], mem2[0]);
            exp_pred  = dp;
            exp_cyc   = 2;
        end else begin
            exp_pred  = dp;
            exp_taken = 1'b1;
            for (int i = 0; i < n; i++) begin
                c = ref_cmp(f, v1 ? mem1[i] : mem1[0], v2 ? mem2[i] : mem2[0]);
                if (sp[i]) begin
                    if (c) exp_pred[i] = 1'b1;
                    else begin
                        exp_taken = 1'b0;
                        if (z) exp_pred[i] = 1'b0;
                    end
                end else if (z) begin
                    exp_pred[i] = 1'b0;
                end
            end
            exp_cyc = (n == 0) ? 1 : n + 1;
        end
    endtask

    task automatic fill(input bit narrow);
        for (int i = 0; i < MVL; i++) begin
            mem1[i] = narrow ? DW'($urandom_range(0, 3)) : DW'($urandom);
            mem2[i] = narrow ? DW'($urandom_range(0, 3)) : DW'($urandom);
        end
    endtask

    task automatic run(input logic [3:0] f, input bit a1, input bit v1, input bit a2,
                       input bit v2, input int vl, input logic [MVL-1:0] sp,
                       input logic [MVL-1:0] dp, input bit z, input bit poke,
                       input string req);
        int cyc;
        logic [MVL-1:0] hold_p;
        bit hold_t;
        model(f, a1 && v1, a2 && v2, vl, sp, dp, z);
        @(negedge clk);
        func_i = f; rs1_act_i = a1; rs1_vec_i = v1; rs2_act_i = a2; rs2_vec_i = v2;
        vl_i = CNT_W'(vl); src_pred_i = sp; dst_pred_i = dp; zero_i = z;
        start_i = 1'b1;
        @(negedge clk);
        cyc = 1;
        if (poke && !done_o) begin
            func_i = ~f; zero_i = ~z; dst_pred_i = ~dp; src_pred_i = ~sp;
            vl_i = vl_i ^ 1'b1;
        end else begin
            start_i = 1'b0;
        end
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check(cyc == exp_cyc, "R2", "done latency", cyc, exp_cyc);
        check(pred_o == exp_pred, poke ? "R10" : req, "pred_o", pred_o, exp_pred);
        check(taken_o == exp_taken, poke ? "R10" : "R8", "taken_o", taken_o, exp_taken);
        hold_p = pred_o;
        hold_t = taken_o;
        @(negedge clk);
        check(!done_o, "R2", "done pulse width", done_o, 0);
        check(pred_o == hold_p && taken_o == hold_t, "R11", "held result",
              {pred_o, 7'b0, taken_o}, {hold_p, 7'b0, hold_t});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < MVL; i++) begin mem1[i] = '0; mem2[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1", "busy/done after reset", {busy_o, done_o}, 0);
        check(pred_o == '0, "R1", "pred after reset", pred_o, 0);
        check(!taken_o, "R1", "taken after reset", taken_o, 0);

        // R3: all equal, full mask.
        for (int i = 0; i < MVL; i++) begin mem1[i] = DW'(i); mem2[i] = DW'(i); end
        run(4'b0000, 1, 1, 1, 1, 8, 8'hFF, 8'h00, 0, 0, "R3");
        // R6: zeroing with half the elements masked out, some failing.
        mem2[1] = 8'h55;
        run(4'b0000, 1, 1, 1, 1, 8, 8'h0F, 8'hFF, 1, 0, "R6");
        // R7: set-only, failures and masked elements keep entry bits.
        run(4'b0000, 1, 1, 1, 1, 8, 8'h0F, 8'hA0, 0, 0, "R7");
        // R5 / R8: everything masked out, branch taken vacuously.
        run(4'b0001, 1, 1, 1, 1, 8, 8'h00, 8'h3C, 0, 0, "R5");
        // R8: zero length.
        run(4'b0010, 1, 1, 1, 1, 0, 8'hFF, 8'h81, 1, 0, "R8");
        // R4: scalar first source broadcast against a vector.
        for (int i = 0; i < MVL; i++) begin mem1[i] = DW'(3); mem2[i] = DW'(i); end
        run(4'b0111, 1, 0, 1, 1, 8, 8'hFF, 8'h00, 1, 0, "R4");
        // R4: scalar second source broadcast.
        run(4'b0010, 1, 1, 0, 1, 6, 8'hFF, 8'h00, 0, 0, "R4");
        // R9: both scalar, mask untouched.
        run(4'b0000, 1, 0, 1, 0, 8, 8'h00, 8'h5A, 1, 0, "R9");
        // R2: active without vector flag and vector without active are scalar.
        run(4'b0011, 0, 1, 1, 0, 8, 8'hFF, 8'hC3, 0, 0, "R2");
        // R3: signed versus unsigned at the sign boundary.
        mem1[0] = 8'h80; mem2[0] = 8'h01; mem1[1] = 8'h7F; mem2[1] = 8'hFF;
        run(4'b0010, 1, 1, 1, 1, 2, 8'hFF, 8'h00, 1, 0, "R3");
        run(4'b0110, 1, 1, 1, 1, 2, 8'hFF, 8'h00, 1, 0, "R3");
        // R3: swapped forms (greater than, less or equal).
        run(4'b1010, 1, 1, 1, 1, 8, 8'hFF, 8'h00, 1, 0, "R3");
        run(4'b1111, 1, 1, 1, 1, 8, 8'hFF, 8'h00, 1, 0, "R3");
        // R12: length above MAX_VL.
        run(4'b0011, 1, 1, 1, 1, 15, 8'hFF, 8'h00, 1, 0, "R12");
        // R10: start during a run.
        run(4'b0000, 1, 1, 1, 1, 5, 8'hF7, 8'h10, 1, 1, "R10");

        // Random mix.
        for (int k = 0; k < 300; k++) begin
            fill($urandom_range(0, 3) != 0);
            run(4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                $urandom_range(0, 10), MVL'($urandom), MVL'($urandom), 1'($urandom),
                $urandom_range(0, 7) == 0, "R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule